// File: doc/BRIEF.md
# Keyboard Controller Host Interface

This block is the host-facing side of a keyboard controller. The host sees two byte addresses. One is a data address. The other is a combined command/status address: writing it issues a command and reading it returns status. Behind these sit a one-byte output buffer toward the host, an internal configuration byte, a sampled input port and a driven output port. Several commands load a byte into the output buffer. Two commands arm a capture, so that the next data-address write is stored as an operand instead of being forwarded.

Every host write lands in a one-entry input register and is acted on at the following clock edge. While it waits there, the input-full status flag is set. A data write that no command has claimed goes out on the keyboard-side forward port with a one-cycle strobe. In place of real keyboard traffic, a test-side load input can fill the output buffer. An interrupt output rises on any buffer load if the configuration byte allows it, and a host read of the data address clears it.

Top module: `kbc_host_if`

## Requirements
- R1: After synchronous reset, host_rdata is 0x00, the output port is 0x03 (bit 0 is the no-reset line, bit 1 is the address-line-20 enable), irq_o, kbd_off_o and fwd_strobe are 0, and the status byte reads 0x10.
- R2: Status byte layout: bit 0 is output buffer full; bit 1 is input full, which is high in the cycle after a host write is accepted and low once that write is processed; bit 2 copies configuration bit 2; bit 4 is high while the keyboard is enabled (configuration bit 4 clear); bits 7:5 read 0.
- R3: Status bit 3 is set by a write to the command address and cleared by a write to the data address.
- R4: A data-address read returns the output buffer in host_rdata at the read edge and clears the buffer-full flag and irq_o. host_rdata holds its value between reads.
- R5: Command 0xAA places 0x55 in the output buffer.
- R6: Command 0x20 places the configuration byte in the output buffer. Command 0x60 makes the next data write become the configuration byte.
- R7: With configuration bit 0 set, every output buffer load raises irq_o. With it clear, irq_o stays low.
- R8: Command 0xC0 loads inp_i into the output buffer. Command 0xD0 loads the output port register. Command 0xD1 makes the next data write become the output port.
- R9: For commands 0xF0 to 0xFF, each output port bit i (i = 0..3) whose command bit i is 0 drives low on outp_o for PULSE_LEN cycles starting the cycle after processing and is then restored. Other bits are unaffected.
- R10: Command 0xAD sets configuration bit 4 (kbd_off_o high). Command 0xAE clears it.
- R11: A data write with no capture armed appears on fwd_data with fwd_strobe high for exactly one cycle, two edges after the write.
- R12: A command code not listed here changes nothing: output buffer, flags, configuration byte, output port and any armed capture stay as they were.
- R13: A test_load pulse loads test_data into the output buffer exactly like a controller load (buffer-full flag, interrupt per R7). A command load in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe |
| host_sel_cmd | input | 1 | 1 selects the command/status address, 0 the data address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered host read byte |
| irq_o | output | 1 | Output-buffer interrupt |
| inp_i | input | 8 | Input port sampled by command 0xC0 |
| outp_o | output | 8 | Output port, including pulse gating |
| kbd_off_o | output | 1 | Keyboard disabled (configuration bit 4) |
| fwd_strobe | output | 1 | Forwarded data byte valid |
| fwd_data | output | 8 | Forwarded data byte |
| test_load | input | 1 | Test-side output buffer load |
| test_data | input | 8 | Byte for the test-side load |

## Verification
The command decoder is driven by a table of command sequences. Each one that produces a buffer byte is read back through the data address: 0xAA, 0x20 after a 0x60 write, 0xD0 before and after a 0xD1 write, and 0xC0. This tells apart the different buffer sources and shows that each operand capture reaches the right register. Directed sequences then separate a forwarded data byte from a captured one, an enabled interrupt from a masked one, and a test-side load from a command load. The pulse command is watched cycle by cycle at its last low cycle and its first restored cycle. An unknown code is placed between an armed 0xD1 and its operand, which shows that the code disturbs neither the capture nor the buffer.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam int KBC_DW = 8;
  localparam int KBC_PULSE_BITS = 4;

  typedef enum logic [3:0] {
    OP_NONE, OP_RD_CFG, OP_WR_CFG, OP_SELFTEST, OP_KBD_DIS, OP_KBD_EN,
    OP_RD_IN, OP_RD_OUT, OP_WR_OUT, OP_PULSE
  } kbc_op_e;

  typedef enum logic [1:0] {
    PEND_NONE, PEND_CFG, PEND_OUT
  } kbc_pend_e;

  localparam int STS_OBF = 0;
  localparam int STS_IBF = 1;
  localparam int STS_SYS = 2;
  localparam int STS_CMD = 3;
  localparam int STS_KEN = 4;

  localparam int CFG_IRQ_EN = 0;
  localparam int CFG_SYS    = 2;
  localparam int CFG_KOFF   = 4;

  localparam logic [KBC_DW-1:0] SELFTEST_PASS = 8'h55;
endpackage

// File: rtl/kbc_cmd_decode.sv
module kbc_cmd_decode
  import kbc_pkg::*;
(
  input  logic [KBC_DW-1:0] code,
  output kbc_op_e           op
);
  always_comb begin
    op = OP_NONE;
    if (code[7:4] == 4'hF) begin
      op = OP_PULSE;
    end else begin
      case (code)
        8'h20:   op = OP_RD_CFG;
        8'h60:   op = OP_WR_CFG;
        8'hAA:   op = OP_SELFTEST;
        8'hAD:   op = OP_KBD_DIS;
        8'hAE:   op = OP_KBD_EN;
        8'hC0:   op = OP_RD_IN;
        8'hD0:   op = OP_RD_OUT;
        8'hD1:   op = OP_WR_OUT;
        default: op = OP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/kbc_outbuf.sv
module kbc_outbuf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctrl_load,
  input  logic [DW-1:0] ctrl_data,
  input  logic          test_load,
  input  logic [DW-1:0] test_data,
  input  logic          take,
  input  logic          irq_en,
  output logic [DW-1:0] ob,
  output logic          obf,
  output logic          irq
);
  logic any_load;
  assign any_load = ctrl_load | test_load;

  always_ff @(posedge clk) begin
    if (rst) begin
      ob  <= '0;
      obf <= 1'b0;
      irq <= 1'b0;
    end else if (any_load) begin
      ob  <= ctrl_load ? ctrl_data : test_data;
      obf <= 1'b1;
      irq <= irq_en;
    end else if (take) begin
      obf <= 1'b0;
      irq <= 1'b0;
    end
  end

  AST_IRQ_NEEDS_OBF: assert property (@(posedge clk) disable iff (rst)
    irq |-> obf); // R7
  AST_TAKE_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    (take && !any_load) |=> !obf); // R4
  AST_LOAD_FILLS: assert property (@(posedge clk) disable iff (rst)
    any_load |=> obf); // R13
endmodule

// File: rtl/kbc_pulse.sv
module kbc_pulse #(
  parameter int DW        = 8,
  parameter int NB        = 4,
  parameter int PULSE_LEN = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [NB-1:0] start_mask,
  input  logic [DW-1:0] base,
  output logic [DW-1:0] outp
);
  localparam int CW = $clog2(PULSE_LEN + 1);

  logic [CW-1:0] cnt;
  logic [NB-1:0] mask;
  logic          active;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      mask <= '0;
    end else if (start) begin
      cnt  <= CW'(PULSE_LEN);
      mask <= start_mask;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign active = (cnt != '0);

  generate
    for (genvar i = 0; i < DW; i++) begin : g_bit
      if (i < NB) begin : g_pulsed
        assign outp[i] = base[i] & ~(active & mask[i]);
      end else begin : g_plain
        assign outp[i] = base[i];
      end
    end
  endgenerate

  AST_PULSE_DRIVES_LOW: assert property (@(posedge clk) disable iff (rst)
    start |=> ((outp[NB-1:0] & $past(start_mask)) == '0)); // R9
endmodule

// File: rtl/kbc_host_if.sv
module kbc_host_if
  import kbc_pkg::*;
#(
  parameter int              PULSE_LEN = 8,
  parameter logic [KBC_DW-1:0] OUTP_RST  = 8'h03,
  parameter logic [KBC_DW-1:0] CFG_RST   = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic              host_sel_cmd,
  input  logic [KBC_DW-1:0] host_wdata,
  output logic [KBC_DW-1:0] host_rdata,
  output logic              irq_o,
  input  logic [KBC_DW-1:0] inp_i,
  output logic [KBC_DW-1:0] outp_o,
  output logic              kbd_off_o,
  output logic              fwd_strobe,
  output logic [KBC_DW-1:0] fwd_data,
  input  logic              test_load,
  input  logic [KBC_DW-1:0] test_data
);
  // input stage
  logic              ib_full, ib_cmd, cmd_flag;
  logic [KBC_DW-1:0] ib_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      ib_full  <= 1'b0;
      ib_cmd   <= 1'b0;
      ib_data  <= '0;
      cmd_flag <= 1'b0;
    end else begin
      ib_full <= host_wr;
      if (host_wr) begin
        ib_data  <= host_wdata;
        ib_cmd   <= host_sel_cmd;
        cmd_flag <= host_sel_cmd;
      end
    end
  end

  kbc_op_e op;
  kbc_cmd_decode u_dec (.code(ib_data), .op(op));

  // architectural state
  logic [KBC_DW-1:0] cfg, outport;
  kbc_pend_e         pend;

  logic [KBC_DW-1:0] cfg_n, outport_n, ld_data;
  kbc_pend_e         pend_n;
  logic              ld, pulse_go, fwd_n;

  always_comb begin
    cfg_n     = cfg;
    outport_n = outport;
    pend_n    = pend;
    ld        = 1'b0;
    ld_data   = '0;
    pulse_go  = 1'b0;
    fwd_n     = 1'b0;
    if (ib_full) begin
      if (ib_cmd) begin
        if (op != OP_NONE) pend_n = PEND_NONE;
        case (op)
          OP_RD_CFG:   begin ld = 1'b1; ld_data = cfg; end
          OP_WR_CFG:   pend_n = PEND_CFG;
          OP_SELFTEST: begin ld = 1'b1; ld_data = SELFTEST_PASS; end
          OP_KBD_DIS:  cfg_n[CFG_KOFF] = 1'b1;
          OP_KBD_EN:   cfg_n[CFG_KOFF] = 1'b0;
          OP_RD_IN:    begin ld = 1'b1; ld_data = inp_i; end
          OP_RD_OUT:   begin ld = 1'b1; ld_data = outport; end
          OP_WR_OUT:   pend_n = PEND_OUT;
          OP_PULSE:    pulse_go = 1'b1;
          default:     ;
        endcase
      end else begin
        case (pend)
          PEND_CFG: cfg_n     = ib_data;
          PEND_OUT: outport_n = ib_data;
          default:  fwd_n     = 1'b1;
        endcase
        pend_n = PEND_NONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg        <= CFG_RST;
      outport    <= OUTP_RST;
      pend       <= PEND_NONE;
      fwd_strobe <= 1'b0;
      fwd_data   <= '0;
    end else begin
      cfg        <= cfg_n;
      outport    <= outport_n;
      pend       <= pend_n;
      fwd_strobe <= fwd_n;
      if (fwd_n) fwd_data <= ib_data;
    end
  end

  // output buffer
  logic [KBC_DW-1:0] ob;
  logic              obf;
  logic              take;
  assign take = host_rd & ~host_sel_cmd;

  kbc_outbuf #(.DW(KBC_DW)) u_ob (
    .clk(clk), .rst(rst),
    .ctrl_load(ld), .ctrl_data(ld_data),
    .test_load(test_load), .test_data(test_data),
    .take(take), .irq_en(cfg[CFG_IRQ_EN]),
    .ob(ob), .obf(obf), .irq(irq_o)
  );

  // output port pulse gating
  kbc_pulse #(.DW(KBC_DW), .NB(KBC_PULSE_BITS), .PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst(rst),
    .start(pulse_go), .start_mask(~ib_data[KBC_PULSE_BITS-1:0]),
    .base(outport), .outp(outp_o)
  );

  // status and read path
  logic [KBC_DW-1:0] sts;
  always_comb begin
    sts          = '0;
    sts[STS_OBF] = obf;
    sts[STS_IBF] = ib_full;
    sts[STS_SYS] = cfg[CFG_SYS];
    sts[STS_CMD] = cmd_flag;
    sts[STS_KEN] = ~cfg[CFG_KOFF];
  end

  always_ff @(posedge clk) begin
    if (rst)          host_rdata <= '0;
    else if (host_rd) host_rdata <= host_sel_cmd ? sts : ob;
  end

  assign kbd_off_o = cfg[CFG_KOFF];

  AST_CMD_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_sel_cmd) |=> sts[STS_CMD]); // R3
  AST_CMD_FLAG_CLR: assert property (@(posedge clk) disable iff (rst)
    (host_wr && !host_sel_cmd) |=> !sts[STS_CMD]); // R3
  AST_IBF_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (rst)
    host_wr |=> sts[STS_IBF]); // R2
  AST_FWD_FROM_DATA_WRITE: assert property (@(posedge clk) disable iff (rst)
    fwd_strobe |-> $past(host_wr && !host_sel_cmd, 2)); // R11
endmodule

// File: tb/kbc_host_if_bench.sv
module kbc_host_if_bench;
  localparam int PL = 8;
  localparam int NV = 14;
  // entry: {sel_cmd, byte, do_check, expected}
  localparam logic [17:0] VEC [0:NV-1] = '{
    {1'b1, 8'hAA, 1'b1, 8'h55},
    {1'b1, 8'h60, 1'b0, 8'h00},
    {1'b0, 8'h45, 1'b0, 8'h00},
    {1'b1, 8'h20, 1'b1, 8'h45},
    {1'b1, 8'hD0, 1'b1, 8'h03},
    {1'b1, 8'hD1, 1'b0, 8'h00},
    {1'b0, 8'h0F, 1'b0, 8'h00},
    {1'b1, 8'hD0, 1'b1, 8'h0F},
    {1'b1, 8'hD1, 1'b0, 8'h00},
    {1'b0, 8'h03, 1'b0, 8'h00},
    {1'b1, 8'hC0, 1'b1, 8'hA5},
    {1'b1, 8'h60, 1'b0, 8'h00},
    {1'b0, 8'h00, 1'b0, 8'h00},
    {1'b1, 8'h20, 1'b1, 8'h00}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_wr = 1'b0, host_rd = 1'b0, host_sel_cmd = 1'b0, test_load = 1'b0;
  logic [7:0] host_wdata = 8'h00, inp_i = 8'hA5, test_data = 8'h00;
  logic [7:0] host_rdata, outp_o, fwd_data;
  logic irq_o, kbd_off_o, fwd_strobe;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  kbc_host_if #(.PULSE_LEN(PL)) u_kbc_host_if (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_sel_cmd(host_sel_cmd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .irq_o(irq_o), .inp_i(inp_i), .outp_o(outp_o), .kbd_off_o(kbd_off_o),
    .fwd_strobe(fwd_strobe), .fwd_data(fwd_data),
    .test_load(test_load), .test_data(test_data)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_sel_cmd = sel; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_sel_cmd = sel;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  function automatic string req_of(input logic [7:0] c);
    case (c)
      8'hAA:   return "R5";
      8'h20:   return "R6";
      default: return "R8";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 rdata", host_rdata, 8'h00);
    chk("R1 outp", outp_o, 8'h03);
    chk("R1 irq/koff/strobe", {5'd0, irq_o, kbd_off_o, fwd_strobe}, 8'h00);
    rd(1'b1, d); chk("R1 status", d, 8'h10);

    // R2 input-full flag visible the cycle after a write
    @(negedge clk);
    host_wr = 1'b1; host_sel_cmd = 1'b1; host_wdata = 8'hAE;
    @(negedge clk);
    host_wr = 1'b0; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    chk("R2 ibf set", host_rdata, 8'h1A);
    rd(1'b1, d); chk("R2 ibf clear", d, 8'h18);

    // R11 forward, R3 flag cleared by data write
    wr(1'b0, 8'h3C);
    @(negedge clk);
    chk("R11 strobe", {7'd0, fwd_strobe}, 8'h01);
    chk("R11 data", fwd_data, 8'h3C);
    @(negedge clk);
    chk("R11 one cycle", {7'd0, fwd_strobe}, 8'h00);
    rd(1'b1, d); chk("R3 data write clears", d, 8'h10);

    // table of command sequences
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][17], VEC[i][16:9]);
      if (VEC[i][8]) begin
        rd(1'b0, d);
        chk(req_of(VEC[i][16:9]), d, VEC[i][7:0]);
      end
    end

    // R2 system flag
    wr(1'b1, 8'h60); wr(1'b0, 8'h04);
    rd(1'b1, d); chk("R2 sys flag", d, 8'h14);

    // R7 interrupt enabled
    wr(1'b1, 8'h60); wr(1'b0, 8'h01);
    wr(1'b1, 8'hAA);
    @(negedge clk);
    chk("R7 irq raised", {7'd0, irq_o}, 8'h01);
    rd(1'b1, d); chk("R2 obf status", d, 8'h19);
    rd(1'b0, d); chk("R5 selftest", d, 8'h55);
    chk("R4 irq cleared", {7'd0, irq_o}, 8'h00);
    rd(1'b1, d); chk("R4 obf cleared", d, 8'h18);
    // R7 interrupt masked
    wr(1'b1, 8'h60); wr(1'b0, 8'h00);
    wr(1'b1, 8'hAA);
    @(negedge clk);
    chk("R7 irq masked", {7'd0, irq_o}, 8'h00);
    rd(1'b0, d);

    // R13 test-side load
    @(negedge clk);
    test_load = 1'b1; test_data = 8'h9C;
    @(negedge clk);
    test_load = 1'b0;
    rd(1'b1, d); chk("R13 obf", d, 8'h19);
    rd(1'b0, d); chk("R13 data", d, 8'h9C);

    // R10 keyboard disable / enable
    wr(1'b1, 8'hAD);
    @(negedge clk);
    chk("R10 disable", {7'd0, kbd_off_o}, 8'h01);
    rd(1'b1, d); chk("R10 status", d, 8'h08);
    wr(1'b1, 8'hAE);
    @(negedge clk);
    chk("R10 enable", {7'd0, kbd_off_o}, 8'h00);

    // R9 pulse bit 0
    wr(1'b1, 8'hFE);
    @(negedge clk);
    chk("R9 pulse start", outp_o, 8'h02);
    repeat (PL - 1) @(negedge clk);
    chk("R9 pulse last", outp_o, 8'h02);
    @(negedge clk);
    chk("R9 pulse end", outp_o, 8'h03);

    // R12 unknown command
    wr(1'b1, 8'h77);
    rd(1'b1, d); chk("R12 no load", d, 8'h18);
    wr(1'b1, 8'h20);
    rd(1'b0, d); chk("R12 cfg kept", d, 8'h00);
    wr(1'b1, 8'hD1); wr(1'b1, 8'h77); wr(1'b0, 8'h07);
    @(negedge clk);
    chk("R12 no forward", {7'd0, fwd_strobe}, 8'h00);
    chk("R12 capture kept", outp_o, 8'h07);
    wr(1'b1, 8'hD1); wr(1'b0, 8'h03);
    @(negedge clk);
    chk("R8 outport restore", outp_o, 8'h03);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule